// File: doc/BRIEF.md
# Dual-Channel Acceleration Threshold Interrupt Generator

This block watches a stream of signed three-axis acceleration samples. A strobe marks each new sample, one per output-data-rate period. Two independent detector channels see every sample. Each channel has its own threshold and compares the magnitude of each axis against it. The result is a "high" event (magnitude above the threshold) and a "low" event (magnitude at or below it) for every axis.

A channel keeps only the events that are enabled in its configuration register. It combines them with either OR or AND logic, chosen per channel. When the combined condition holds for a programmable number of consecutive samples, the channel latches an interrupt-active flag and records which enabled events were true at that moment. A routing register places each channel on its own interrupt pin, so one channel can run wake-up detection (OR of the high events) while the other runs free-fall detection (AND of the low events). Firmware reads the source register to find out what happened. That read also acknowledges the interrupt.

All configuration goes through a small byte-wide register port. Samples arrive already scaled to threshold units, so the threshold is compared in raw counts.

Top module: `accel_irq_top`

## Requirements
- R1: After reset every register reads 0x00 and both interrupt pins are low.
- R2: For each axis, the high event is true when |sample| > threshold and the low event is true when |sample| <= threshold. Comparison is in raw counts; the most negative sample value has magnitude 2^(SAMPLE_W-1).
- R3: With the combine bit (config bit 7) at 0, a sample qualifies when at least one enabled event is true. Enable bits in the config register are: bit 5 Z-high, bit 4 Z-low, bit 3 Y-high, bit 2 Y-low, bit 1 X-high, bit 0 X-low.
- R4: With the combine bit at 1, a sample qualifies only when every enabled event is true.
- R5: When none of config bits 5..0 is set, the channel never raises its interrupt, whatever the combine bit says.
- R6: With a duration value N, the interrupt latches on the (N+1)-th consecutive qualifying sample, so N=0 latches on the first one. A non-qualifying sample restarts the count. A write to the channel's config, threshold or duration register also restarts it.
- R7: When the interrupt latches, the source register reads bit 7 = 0, bit 6 = interrupt active, and bits 5..0 = the enabled events true on the firing sample, in the enable-bit layout. This value holds until it is read.
- R8: A read of the source register returns the latched value and clears it in the same cycle, which drops the pin. A firing sample in that same cycle wins over the clear.
- R9: The config register reads back all 8 bits as written, including bit 6, which is stored but has no effect on detection. Threshold and duration keep bits 6..0 and read bit 7 as 0.
- R10: Channel 0 uses addresses 0x30 (config), 0x31 (source), 0x32 (threshold) and 0x33 (duration). Channel 1 uses 0x34 to 0x37 in the same order. The routing register is at 0x38. Pin k is high exactly when channel k's interrupt is active and routing bit k is 1.
- R11: The two channels run independently and can both hold their pins high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe: a new sample set is present |
| smp_x | input | SAMPLE_W | Signed X-axis sample |
| smp_y | input | SAMPLE_W | Signed Y-axis sample |
| smp_z | input | SAMPLE_W | Signed Z-axis sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledges the source register) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq_o | output | 2 | Interrupt pins, bit k driven by channel k |

## Verification
The in-RTL assertions check several invariants on every cycle. The sample counter never passes the duration value. A channel with no enabled events stays quiet. The interrupt flag is never set without recorded event bits, and the flag only rises on a sample strobe. In AND mode the recorded bits equal the enable mask. A pin only rises after a sample or a routing write, and an acknowledging read with no sample in the same cycle drops the flag.

Other behaviour can only be shown by the bench scenarios, driven by directed and seeded-random sample streams:
- the exact firing sample under different durations;
- the count restarting after a broken streak;
- the threshold boundary at equality and at the most negative sample;
- free-fall and wake-up running together on separate pins;
- read-back of the register layouts.

// File: rtl/accel_irq_pkg.sv
package accel_irq_pkg;

    localparam int REG_W      = 8;
    localparam int THS_W      = 7;
    localparam int DUR_W      = 7;
    localparam int NUM_GEN    = 2;
    localparam int NUM_AXIS   = 3;
    localparam int NUM_EVT    = 2 * NUM_AXIS;
    localparam int GEN_STRIDE = 4;

    localparam logic [REG_W-1:0] GEN_BASE   = 8'h30;
    localparam logic [REG_W-1:0] ROUTE_ADDR = 8'h38;

    localparam logic [1:0] OFS_CFG = 2'd0;
    localparam logic [1:0] OFS_SRC = 2'd1;
    localparam logic [1:0] OFS_THS = 2'd2;
    localparam logic [1:0] OFS_DUR = 2'd3;

    typedef struct packed {
        logic               use_and;
        logic               dir6_en;
        logic [NUM_EVT-1:0] evt_en;
    } chan_cfg_t;

endpackage

// File: rtl/accel_axis_cmp.sv
module accel_axis_cmp #(
    parameter int SAMPLE_W = 8,
    parameter int THS_W    = 7
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [THS_W-1:0]    ths_i,
    output logic                       above_o,
    output logic                       below_o
);
    localparam int MAG_W = ((SAMPLE_W + 1) > THS_W) ? (SAMPLE_W + 1) : THS_W;

    logic [MAG_W-1:0] ext_s;
    logic [MAG_W-1:0] mag_s;
    logic [MAG_W-1:0] ths_ext;

    always_comb begin
        ext_s   = MAG_W'(sample_i);
        mag_s   = sample_i[SAMPLE_W-1] ? (~ext_s + MAG_W'(1)) : ext_s;
        ths_ext = MAG_W'(ths_i);
        above_o = mag_s > ths_ext;
        below_o = !above_o;
    end

endmodule

// File: rtl/accel_irq_gen.sv
module accel_irq_gen
    import accel_irq_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic signed [SAMPLE_W-1:0] smp_x_i,
    input  logic signed [SAMPLE_W-1:0] smp_y_i,
    input  logic signed [SAMPLE_W-1:0] smp_z_i,
    input  logic                       cfg_wr_i,
    input  logic                       ths_wr_i,
    input  logic                       dur_wr_i,
    input  logic        [REG_W-1:0]    wdata_i,
    input  logic                       src_rd_i,
    output logic        [REG_W-1:0]    cfg_o,
    output logic        [REG_W-1:0]    src_o,
    output logic        [REG_W-1:0]    ths_o,
    output logic        [REG_W-1:0]    dur_o,
    output logic                       ia_o
);
    typedef struct packed {
        chan_cfg_t          cfg;
        logic [THS_W-1:0]   ths;
        logic [DUR_W-1:0]   dur;
        logic [DUR_W-1:0]   cnt;
        logic [NUM_EVT-1:0] flags;
        logic               ia;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic signed [SAMPLE_W-1:0] axis_smp [NUM_AXIS];
    logic [NUM_AXIS-1:0]        axis_hi;
    logic [NUM_AXIS-1:0]        axis_lo;
    logic [NUM_EVT-1:0]         evt_now;
    logic [NUM_EVT-1:0]         evt_hit;
    logic                       any_en;
    logic                       qualify;
    logic                       dur_met;
    logic                       fire;

    assign axis_smp[0] = smp_x_i;
    assign axis_smp[1] = smp_y_i;
    assign axis_smp[2] = smp_z_i;

    for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
        accel_axis_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .THS_W    (THS_W)
        ) u_cmp (
            .sample_i (axis_smp[a]),
            .ths_i    (st_q.ths),
            .above_o  (axis_hi[a]),
            .below_o  (axis_lo[a])
        );
        assign evt_now[2*a]     = axis_lo[a];
        assign evt_now[2*a + 1] = axis_hi[a];
    end

    always_comb begin
        st_d    = st_q;
        evt_hit = evt_now & st_q.cfg.evt_en;
        any_en  = |st_q.cfg.evt_en;
        if (st_q.cfg.use_and) begin
            qualify = any_en && ((evt_now | ~st_q.cfg.evt_en) == {NUM_EVT{1'b1}});
        end else begin
            qualify = |evt_hit;
        end
        dur_met = st_q.cnt >= st_q.dur;
        fire    = tick_i && qualify && dur_met;

        if (tick_i) begin
            if (!qualify) begin
                st_d.cnt = '0;
            end else if (!dur_met) begin
                st_d.cnt = st_q.cnt + DUR_W'(1);
            end
        end

        if (src_rd_i) begin
            st_d.ia    = 1'b0;
            st_d.flags = '0;
        end
        if (fire && (!st_q.ia || src_rd_i)) begin
            st_d.ia    = 1'b1;
            st_d.flags = evt_hit;
        end

        if (cfg_wr_i) begin
            st_d.cfg = chan_cfg_t'(wdata_i);
            st_d.cnt = '0;
        end
        if (ths_wr_i) begin
            st_d.ths = wdata_i[THS_W-1:0];
            st_d.cnt = '0;
        end
        if (dur_wr_i) begin
            st_d.dur = wdata_i[DUR_W-1:0];
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = REG_W'(st_q.cfg);
    assign src_o = {1'b0, st_q.ia, st_q.flags};
    assign ths_o = REG_W'(st_q.ths);
    assign dur_o = REG_W'(st_q.dur);
    assign ia_o  = st_q.ia;

    // R6: the streak counter saturates at the duration value
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.dur);

    // R6: the flag only rises on a sample strobe
    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ia) |-> $past(tick_i));

    // R5: with no enabled events a clear flag stays clear
    a_r5_no_enable_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ia && st_q.cfg.evt_en == '0) |=> !st_q.ia);

    // R7: flag and recorded event bits are set and cleared together
    a_r7_flags_with_ia: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ia == (st_q.flags != '0));

    // R8: an acknowledging read without a sample clears the flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_i && !tick_i) |=> !st_q.ia);

    // R4: in AND mode the recorded bits equal the enable mask
    a_r4_and_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.ia) && $past(st_q.cfg.use_and)) |-> st_q.flags == $past(st_q.cfg.evt_en));

endmodule

// File: rtl/accel_irq_top.sv
module accel_irq_top
    import accel_irq_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] smp_x,
    input  logic signed [SAMPLE_W-1:0] smp_y,
    input  logic signed [SAMPLE_W-1:0] smp_z,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic        [REG_W-1:0]    reg_addr,
    input  logic        [REG_W-1:0]    reg_wdata,
    output logic        [REG_W-1:0]    reg_rdata,
    output logic        [NUM_GEN-1:0]  irq_o
);
    typedef struct packed {
        logic [NUM_GEN-1:0] route;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_GEN-1:0] gen_hit;
    logic [NUM_GEN-1:0] gen_ia;
    logic [REG_W-1:0]   cfg_rd [NUM_GEN];
    logic [REG_W-1:0]   src_rd [NUM_GEN];
    logic [REG_W-1:0]   ths_rd [NUM_GEN];
    logic [REG_W-1:0]   dur_rd [NUM_GEN];
    logic               route_sel;

    assign route_sel = reg_addr == ROUTE_ADDR;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        localparam logic [REG_W-1:0] BASE = GEN_BASE + REG_W'(g * GEN_STRIDE);

        assign gen_hit[g] = reg_addr[REG_W-1:2] == BASE[REG_W-1:2];

        accel_irq_gen #(
            .SAMPLE_W (SAMPLE_W)
        ) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (sample_valid),
            .smp_x_i  (smp_x),
            .smp_y_i  (smp_y),
            .smp_z_i  (smp_z),
            .cfg_wr_i (reg_wr && gen_hit[g] && reg_addr[1:0] == OFS_CFG),
            .ths_wr_i (reg_wr && gen_hit[g] && reg_addr[1:0] == OFS_THS),
            .dur_wr_i (reg_wr && gen_hit[g] && reg_addr[1:0] == OFS_DUR),
            .wdata_i  (reg_wdata),
            .src_rd_i (reg_rd && gen_hit[g] && reg_addr[1:0] == OFS_SRC),
            .cfg_o    (cfg_rd[g]),
            .src_o    (src_rd[g]),
            .ths_o    (ths_rd[g]),
            .dur_o    (dur_rd[g]),
            .ia_o     (gen_ia[g])
        );

        assign irq_o[g] = gen_ia[g] && st_q.route[g];

        // R10: a pin rises only after a sample or a routing write
        a_r10_pin_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[g]) |-> ($past(sample_valid) || $past(reg_wr && route_sel)));
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && route_sel) begin
            st_d.route = reg_wdata[NUM_GEN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (gen_hit[g]) begin
                case (reg_addr[1:0])
                    OFS_CFG: reg_rdata = cfg_rd[g];
                    OFS_SRC: reg_rdata = src_rd[g];
                    OFS_THS: reg_rdata = ths_rd[g];
                    default: reg_rdata = dur_rd[g];
                endcase
            end
        end
        if (route_sel) begin
            reg_rdata = REG_W'(st_q.route);
        end
    end

endmodule

// File: tb/accel_irq_top_bench.sv
`timescale 1ns/1ps
module accel_irq_top_bench;

    localparam int SW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic                 reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]           reg_addr = '0, reg_wdata = '0;
    logic [7:0]           reg_rdata;
    logic [1:0]           irq_o;

    always #10 clk = ~clk;

    accel_irq_top #(.SAMPLE_W(SW)) u_accel_irq_top (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    // reference state, built from the requirements
    logic [7:0] m_cfg [2];
    logic [6:0] m_ths [2];
    logic [6:0] m_dur [2];
    int         m_cnt [2];
    logic [5:0] m_flg [2];
    bit         m_ia  [2];
    logic [1:0] m_route;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int absv(input logic signed [SW-1:0] v);
        int i = v;
        return (i < 0) ? -i : i;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        for (int g = 0; g < 2; g++) begin
            if (a == 8'h30 + 8'(4 * g)) return m_cfg[g];
            if (a == 8'h31 + 8'(4 * g)) return {1'b0, m_ia[g], m_flg[g]};
            if (a == 8'h32 + 8'(4 * g)) return {1'b0, m_ths[g]};
            if (a == 8'h33 + 8'(4 * g)) return {1'b0, m_dur[g]};
        end
        if (a == 8'h38) return {6'b0, m_route};
        return 8'h00;
    endfunction

    function automatic logic [1:0] model_pins();
        return {m_ia[1] & m_route[1], m_ia[0] & m_route[0]};
    endfunction

    task automatic model_step(input bit tk, input logic signed [SW-1:0] sx, sy, sz,
                              input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] wd);
        for (int g = 0; g < 2; g++) begin
            logic [5:0] ev, hit, en;
            bit q, fire;
            int t = m_ths[g];
            ev[0] = absv(sx) <= t; ev[1] = absv(sx) > t;
            ev[2] = absv(sy) <= t; ev[3] = absv(sy) > t;
            ev[4] = absv(sz) <= t; ev[5] = absv(sz) > t;
            en  = m_cfg[g][5:0];
            hit = ev & en;
            q   = m_cfg[g][7] ? ((en != 0) && (hit == en)) : (hit != 0);
            fire = tk && q && (m_cnt[g] >= m_dur[g]);
            if (tk) m_cnt[g] = !q ? 0 : ((m_cnt[g] < m_dur[g]) ? m_cnt[g] + 1 : m_cnt[g]);
            if (rd && a == 8'h31 + 8'(4 * g)) begin m_ia[g] = 0; m_flg[g] = 0; end
            if (fire && !m_ia[g]) begin m_ia[g] = 1; m_flg[g] = hit; end
            if (wr && a == 8'h30 + 8'(4 * g)) begin m_cfg[g] = wd;      m_cnt[g] = 0; end
            if (wr && a == 8'h32 + 8'(4 * g)) begin m_ths[g] = wd[6:0]; m_cnt[g] = 0; end
            if (wr && a == 8'h33 + 8'(4 * g)) begin m_dur[g] = wd[6:0]; m_cnt[g] = 0; end
        end
        if (wr && a == 8'h38) m_route = wd[1:0];
    endtask

    // one clock: drive at negedge, check read data before the edge,
    // update the model at the edge, check the pins 2 ns later
    task automatic cyc(input bit tk, input logic signed [SW-1:0] sx, sy, sz,
                       input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] wd,
                       input bit use_exp, input logic [7:0] exp, input string req);
        @(negedge clk);
        sample_valid = tk; smp_x = sx; smp_y = sy; smp_z = sz;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #2;
        if (rd) chk(req, reg_rdata, use_exp ? exp : model_read(a));
        @(posedge clk);
        model_step(tk, sx, sy, sz, wr, rd, a, wd);
        #2;
        chk("R10 pins vs model", irq_o, model_pins());
        sample_valid = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic tick(input logic signed [SW-1:0] sx, sy, sz);
        cyc(1, sx, sy, sz, 0, 0, 8'h00, 8'h00, 0, 8'h00, "");
    endtask
    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        cyc(0, 0, 0, 0, 1, 0, a, d, 0, 8'h00, "");
    endtask
    task automatic rexp(input logic [7:0] a, input logic [7:0] e, input string req);
        cyc(0, 0, 0, 0, 0, 1, a, 8'h00, 1, e, req);
    endtask
    task automatic pin_is(input int g, input bit v, input string req);
        chk(req, irq_o[g], v);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 2; g++) begin
            m_cfg[g] = 0; m_ths[g] = 0; m_dur[g] = 0; m_cnt[g] = 0; m_flg[g] = 0; m_ia[g] = 0;
        end
        m_route = 0;
        void'($urandom(32'd20161));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pins after reset", irq_o, 2'b00);
        for (int a = 8'h30; a <= 8'h38; a++) rexp(8'(a), 8'h00, "R1 register reset");

        // R9: read-back layouts
        wreg(8'h30, 8'hFF); rexp(8'h30, 8'hFF, "R9 cfg readback");
        wreg(8'h32, 8'hFF); rexp(8'h32, 8'h7F, "R9 ths bit7 zero");
        wreg(8'h33, 8'h85); rexp(8'h33, 8'h05, "R9 dur bit7 zero");
        wreg(8'h34, 8'h40); rexp(8'h34, 8'h40, "R9 dir6 bit stored");
        wreg(8'h38, 8'h03); rexp(8'h38, 8'h03, "R10 route readback");

        // R5: no enables, both combine modes
        wreg(8'h30, 8'h80); wreg(8'h32, 8'd10); wreg(8'h33, 8'd0);
        repeat (3) tick(0, 0, 0);
        pin_is(0, 0, "R5 AND no enables");
        wreg(8'h30, 8'h00);
        repeat (3) tick(100, -100, 100);
        pin_is(0, 0, "R5 OR no enables");
        rexp(8'h31, 8'h00, "R5 source stays empty");

        // free-fall on channel 1: AND of the low events, duration 3
        wreg(8'h34, 8'h95); wreg(8'h36, 8'd10); wreg(8'h37, 8'd3);
        repeat (3) tick(5, -3, 10);
        pin_is(1, 0, "R6 before duration");
        tick(5, -3, 11);
        pin_is(1, 0, "R6 broken streak");
        repeat (3) tick(5, -3, -10);
        pin_is(1, 0, "R6 count restarted");
        tick(0, 0, 0);
        pin_is(1, 1, "R6 fires on sample N+1");
        rexp(8'h35, 8'h55, "R7 free-fall source");
        pin_is(1, 0, "R8 pin drops after read");

        // wake-up on channel 0: OR of the high events, duration 0
        wreg(8'h30, 8'h2A); wreg(8'h32, 8'd50); wreg(8'h33, 8'd0);
        tick(-60, 0, 0);
        pin_is(0, 1, "R3 OR fires on first sample");
        repeat (4) tick(5, 5, 5);
        chk("R11 both pins high", irq_o, 2'b11);
        rexp(8'h31, 8'h42, "R7 wake-up source");
        rexp(8'h35, 8'h55, "R11 channel 1 source");

        // R2: threshold boundary and most negative sample
        tick(50, -50, 50);
        pin_is(0, 0, "R2 equal is not high");
        tick(0, 0, -51);
        rexp(8'h31, 8'h60, "R2 above threshold z high");
        wreg(8'h32, 8'd127);
        tick(-128, 0, 0);
        rexp(8'h31, 8'h42, "R2 most negative magnitude");

        // R4: AND mode
        wreg(8'h30, 8'h83); wreg(8'h32, 8'd20);
        repeat (4) tick(30, 0, 0);
        pin_is(0, 0, "R4 contradictory AND never fires");
        wreg(8'h30, 8'hA2);
        tick(30, 0, 10);
        pin_is(0, 0, "R4 partial AND");
        tick(30, 0, -30);
        rexp(8'h31, 8'h62, "R4 full AND");

        // R10: routing masks the pin, not the flag
        rexp(8'h35, model_read(8'h35), "R8 clear channel 1");
        wreg(8'h38, 8'h01);
        repeat (4) tick(1, 1, 1);
        pin_is(1, 0, "R10 unrouted pin low");
        rexp(8'h35, 8'h55, "R10 flag set while unrouted");
        wreg(8'h38, 8'h03);

        // seeded random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 100;
            if (r < 60) begin
                logic signed [SW-1:0] v [3];
                for (int k = 0; k < 3; k++)
                    v[k] = ($urandom % 3 == 0) ? SW'($urandom) : SW'(int'($urandom % 41) - 20);
                tick(v[0], v[1], v[2]);
            end else if (r < 75) begin
                logic [7:0] a = 8'h30 + 8'($urandom % 9);
                cyc(0, 0, 0, 0, 0, 1, a, 8'h00, 0, 8'h00, "R7 R9 random readback");
            end else if (r < 82) begin
                int sel = $urandom % 3;
                int g = $urandom % 2;
                logic [7:0] d = (sel == 0) ? 8'($urandom) : (sel == 1 ? 8'($urandom % 40) : 8'($urandom % 4));
                wreg(8'h30 + 8'(4 * g) + ((sel == 0) ? 8'd0 : (sel == 1 ? 8'd2 : 8'd3)), d);
            end else if (r < 84) begin
                wreg(8'h38, 8'($urandom % 4));
            end else begin
                cyc(1, SW'($urandom), SW'($urandom), SW'($urandom), 0, 1,
                    8'h31 + 8'(4 * ($urandom % 2)), 8'h00, 0, 8'h00, "R8 read with sample");
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule